// File: doc/BRIEF.md
# UART register front end with FIFO watermark interrupt

This block sits between a 32-bit word-addressed register bus and two byte streams, one inbound and one outbound. Software writes outgoing bytes into an 8-entry transmit queue, which drains over a valid/ready byte output. Software reads incoming bytes from an 8-entry receive queue, which is filled from a valid/ready byte input. Serial framing and bit timing belong to a neighbouring block. This block only holds the baud divisor and drives it out to that neighbour.

A single level-sensitive interrupt line is raised from two watermark conditions. The receive watermark asserts when the receive queue holds more bytes than a programmed threshold. The transmit watermark asserts when the transmit queue holds fewer bytes than a programmed threshold. Each condition has its own enable bit. An empty receive queue is reported in the read data itself: bit 31 is set and the low byte is zero.

Register offsets, byte addressed, word aligned:
- 0x00 transmit data
- 0x04 receive data
- 0x08 transmit control
- 0x0C receive control
- 0x10 interrupt enable
- 0x14 interrupt pending
- 0x18 divisor

In both control registers the threshold field sits in bits 19:16. In the enable and pending registers, bit 0 is the transmit watermark and bit 1 is the receive watermark.

Top module: `uart_wm_top`

## Requirements
- R1: After reset the transmit control, receive control, enable, divisor and pending registers all read 0. Both queues are empty: rx_ready_o is 1, tx_valid_o is 0 and irq_o is 0.
- R2: The enable, transmit control, receive control and divisor registers read back the last full-word value written to them, and div_o equals the divisor register.
- R3: A read of receive data at 0x04 with a non-empty receive queue returns the oldest byte in bits 7:0, with bits 31:8 zero. The read removes that byte, so bytes come out in arrival order.
- R4: A read of receive data with an empty receive queue returns 0x80000000 and removes nothing.
- R5: With 8 bytes queued for receive, rx_ready_o is 0 and a further offered byte is discarded. The 8 stored bytes stay intact.
- R6: A full-word write to 0x00 queues bits 7:0 of the written word. Queued bytes appear on tx_data_o with tx_valid_o high, in write order, and one leaves per cycle in which tx_ready_i is high.
- R7: A write to 0x00 while 8 bytes are already queued for transmit is dropped.
- R8: Pending bit 1 (receive watermark) is 1 exactly when the receive level is strictly greater than bits 19:16 of receive control.
- R9: Pending bit 0 (transmit watermark) is 1 exactly when the transmit level is strictly less than bits 19:16 of transmit control.
- R10: irq_o is 1 exactly when some pending bit is 1 together with the enable bit at the same position. It follows the queue levels with no stored state.
- R11: The following accesses are ignored and read as 0: any access whose byte enables are not all ones, any access to an unmapped or unaligned offset, and any write to the pending register. Such an access does not pop the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the access |
| be_i | input | 4 | Byte enables; only 4'hF is a legal access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| rx_data_i | input | 8 | Inbound byte |
| rx_valid_i | input | 1 | Inbound byte valid |
| rx_ready_o | output | 1 | Receive queue can accept a byte |
| tx_data_o | output | 8 | Outbound byte (head of transmit queue) |
| tx_valid_o | output | 1 | Transmit queue non-empty |
| tx_ready_i | input | 1 | Consumer takes the outbound byte |
| div_o | output | 32 | Stored baud divisor |
| irq_o | output | 1 | Watermark interrupt, level |

## Verification
The bench fills each queue one byte past capacity. A design that let the ninth byte through would either corrupt the oldest entry or show nine bytes on readback. Empty receive reads are issued back to back: a design that decremented an empty level would wrap it and return stale data. The watermark thresholds are crossed one byte at a time in both directions, so an off-by-one compare (>= for >, or <= for <) shows up as a pending bit one byte early or late. An interrupt held by a stored flag would stay high after the level falls back. Partial-enable and misaligned reads of the receive register expose a decoder that pops on any hit of the offset.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;
  localparam int unsigned BUS_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_LSB = 16;
  localparam int unsigned IP_TX = 0;
  localparam int unsigned IP_RX = 1;
  localparam logic [BUS_W-1:0] RX_EMPTY_WORD = 32'h8000_0000;

  typedef enum logic [2:0] {
    SEL_TXD = 3'd0,
    SEL_RXD = 3'd1,
    SEL_TXC = 3'd2,
    SEL_RXC = 3'd3,
    SEL_IEN = 3'd4,
    SEL_IPD = 3'd5,
    SEL_DIV = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/uart_wm_fifo.sv
module uart_wm_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W = 8,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;  // full drops, even with a pop
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];
  assign level_o = cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= bump(wr_q);
      if (do_pop)  rd_q <= bump(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH)); // R5
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(wr_q))); // R7
  AST_EMPTY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> (empty_o && $stable(rd_q))); // R4
endmodule

// File: rtl/uart_wm_irq.sv
module uart_wm_irq #(
  parameter int unsigned LW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] tx_level_i,
  input  logic [LW-1:0] rx_level_i,
  input  logic [LW-1:0] tx_mark_i,
  input  logic [LW-1:0] rx_mark_i,
  input  logic [1:0]    ie_i,
  output logic [1:0]    ip_o,
  output logic          irq_o
);
  import uart_wm_pkg::*;

  always_comb begin
    ip_o        = '0;
    ip_o[IP_TX] = (tx_level_i < tx_mark_i);
    ip_o[IP_RX] = (rx_level_i > rx_mark_i);
  end

  assign irq_o = |(ip_o & ie_i);

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ie_i == 2'b00) |-> !irq_o); // R10
  AST_RX_WM_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_level_i == '0) |-> !ip_o[IP_RX]); // R8
endmodule

// File: rtl/uart_wm_csr.sv
module uart_wm_csr #(
  parameter int unsigned AW = 8,
  parameter int unsigned LW = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               req_i,
  input  logic                               we_i,
  input  logic [AW-1:0]                      addr_i,
  input  logic [3:0]                         be_i,
  input  logic [uart_wm_pkg::BUS_W-1:0]      wdata_i,
  output logic [uart_wm_pkg::BUS_W-1:0]      rdata_o,
  input  logic [uart_wm_pkg::BYTE_W-1:0]     rx_byte_i,
  input  logic                               rx_empty_i,
  output logic                               rx_pop_o,
  output logic                               tx_push_o,
  output logic [uart_wm_pkg::BYTE_W-1:0]     tx_byte_o,
  input  logic [1:0]                         ip_i,
  output logic [1:0]                         ie_o,
  output logic [LW-1:0]                      tx_mark_o,
  output logic [LW-1:0]                      rx_mark_o,
  output logic [uart_wm_pkg::BUS_W-1:0]      div_o
);
  import uart_wm_pkg::*;

  logic [BUS_W-1:0] ie_q, txc_q, rxc_q, div_q;
  logic             legal, wr, rd;
  reg_sel_e         sel;

  always_comb begin
    legal = req_i && (be_i == 4'hF) && (addr_i[1:0] == 2'b00) &&
            (addr_i[AW-1:5] == '0) && (addr_i[4:2] != SEL_NONE);
    sel   = legal ? reg_sel_e'(addr_i[4:2]) : SEL_NONE;
  end

  assign wr = legal && we_i;
  assign rd = legal && !we_i;

  assign rx_pop_o  = rd && (sel == SEL_RXD) && !rx_empty_i;
  assign tx_push_o = wr && (sel == SEL_TXD);
  assign tx_byte_o = wdata_i[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= '0;
      txc_q <= '0;
      rxc_q <= '0;
      div_q <= '0;
    end else if (wr) begin
      case (sel)
        SEL_IEN: ie_q  <= wdata_i;
        SEL_TXC: txc_q <= wdata_i;
        SEL_RXC: rxc_q <= wdata_i;
        SEL_DIV: div_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (sel)
        SEL_RXD: rdata_o = rx_empty_i ? RX_EMPTY_WORD
                                      : {{(BUS_W-BYTE_W){1'b0}}, rx_byte_i};
        SEL_TXC: rdata_o = txc_q;
        SEL_RXC: rdata_o = rxc_q;
        SEL_IEN: rdata_o = ie_q;
        SEL_IPD: rdata_o = {{(BUS_W-2){1'b0}}, ip_i};
        SEL_DIV: rdata_o = div_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign ie_o      = ie_q[1:0];
  assign tx_mark_o = txc_q[CNT_LSB +: LW];
  assign rx_mark_o = rxc_q[CNT_LSB +: LW];
  assign div_o     = div_q;

  AST_PARTIAL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (be_i != 4'hF)) |=> ($stable(div_q) && $stable(ie_q))); // R11
  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(div_q)); // R2
endmodule

// File: rtl/uart_wm_top.sv
module uart_wm_top #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW = 8,
  localparam int unsigned LW = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [7:0]  rx_data_i,
  input  logic        rx_valid_i,
  output logic        rx_ready_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_valid_o,
  input  logic        tx_ready_i,
  output logic [31:0] div_o,
  output logic        irq_o
);
  logic [LW-1:0] rx_level, tx_level, tx_mark, rx_mark;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic          rx_pop, tx_push;
  logic [7:0]    rx_head, tx_byte;
  logic [1:0]    ip, ie;

  uart_wm_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_valid_i), .data_i(rx_data_i),
    .pop_i(rx_pop), .data_o(rx_head),
    .level_o(rx_level), .full_o(rx_full), .empty_o(rx_empty)
  );

  uart_wm_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(tx_push), .data_i(tx_byte),
    .pop_i(tx_ready_i), .data_o(tx_data_o),
    .level_o(tx_level), .full_o(tx_full), .empty_o(tx_empty)
  );

  uart_wm_csr #(.AW(AW), .LW(LW)) u_csr (
    .clk_i, .rst_ni,
    .req_i, .we_i, .addr_i, .be_i, .wdata_i, .rdata_o,
    .rx_byte_i(rx_head), .rx_empty_i(rx_empty), .rx_pop_o(rx_pop),
    .tx_push_o(tx_push), .tx_byte_o(tx_byte),
    .ip_i(ip), .ie_o(ie), .tx_mark_o(tx_mark), .rx_mark_o(rx_mark),
    .div_o
  );

  uart_wm_irq #(.LW(LW)) u_irq (
    .clk_i, .rst_ni,
    .tx_level_i(tx_level), .rx_level_i(rx_level),
    .tx_mark_i(tx_mark), .rx_mark_i(rx_mark),
    .ie_i(ie), .ip_o(ip), .irq_o
  );

  assign rx_ready_o = !rx_full;
  assign tx_valid_o = !tx_empty;

  logic rx_rd_chk, rx_in_chk;
  assign rx_rd_chk = req_i && !we_i && (be_i == 4'hF) && (addr_i == 8'h04);
  assign rx_in_chk = rx_valid_i && rx_ready_o;

  AST_RX_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_chk && rx_level == '0) |-> (rdata_o == 32'h8000_0000)); // R4
  AST_RX_POP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rd_chk && rx_level != '0 && !rx_in_chk) |=>
      (rx_level == $past(rx_level) - LW'(1))); // R3
  AST_TX_FULL_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full && !tx_ready_i) |=> tx_full); // R7
endmodule

// File: tb/sim_uart_wm_top.sv
module sim_uart_wm_top;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [3:0]  be = 4'hF;
  logic [31:0] wdata = 0, rdata, div;
  logic [7:0]  rx_data = 0, tx_data;
  logic        rx_valid = 0, rx_ready, tx_valid, tx_ready = 0, irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_wm_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .rx_data_i(rx_data),
    .rx_valid_i(rx_valid), .rx_ready_o(rx_ready), .tx_data_o(tx_data),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .div_o(div), .irq_o(irq)
  );

  localparam logic [7:0] A_TXD = 8'h00, A_RXD = 8'h04, A_TXC = 8'h08,
                         A_RXC = 8'h0C, A_IEN = 8'h10, A_IPD = 8'h14,
                         A_DIV = 8'h18;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; be = b;
    @(negedge clk); req = 0; we = 0; be = 4'hF;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk); req = 1; we = 0; addr = a; be = b;
    #2 d = rdata;
    @(negedge clk); req = 0; be = 4'hF;
  endtask

  task automatic rx_push(input logic [7:0] v, output logic acc);
    @(negedge clk); rx_valid = 1; rx_data = v;
    #2 acc = rx_ready;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic tx_pop(output logic [7:0] d, output logic v);
    @(negedge clk); tx_ready = 1;
    #2 v = tx_valid; d = tx_data;
    @(negedge clk); tx_ready = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_TXC, d); chk("R1 txc", d, 0);
    rd(A_RXC, d); chk("R1 rxc", d, 0);
    rd(A_IEN, d); chk("R1 ien", d, 0);
    rd(A_DIV, d); chk("R1 div", d, 0);
    rd(A_IPD, d); chk("R1 ipd", d, 0);
    chk("R1 rx_ready", {31'b0, rx_ready}, 1);
    chk("R1 tx_valid", {31'b0, tx_valid}, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_csr;
    logic [31:0] d;
    wr(A_IEN, 32'hA5A5_0000);
    wr(A_TXC, 32'h1234_5678);
    wr(A_RXC, 32'hCAFE_0F00);
    wr(A_DIV, 32'h0001_B207);
    rd(A_IEN, d); chk("R2 ien", d, 32'hA5A5_0000);
    rd(A_TXC, d); chk("R2 txc", d, 32'h1234_5678);
    rd(A_RXC, d); chk("R2 rxc", d, 32'hCAFE_0F00);
    rd(A_DIV, d); chk("R2 div", d, 32'h0001_B207);
    chk("R2 div_o", div, 32'h0001_B207);
    wr(A_IEN, 0); wr(A_TXC, 0); wr(A_RXC, 0);
  endtask

  task automatic t_rx_order;
    logic [31:0] d; logic a;
    rx_push(8'h11, a); rx_push(8'h22, a); rx_push(8'h33, a);
    rd(A_RXD, d); chk("R3 first", d, 32'h11);
    rd(A_RXD, d); chk("R3 second", d, 32'h22);
    rd(A_RXD, d); chk("R3 third", d, 32'h33);
    rd(A_RXD, d); chk("R4 empty", d, 32'h8000_0000);
    rd(A_RXD, d); chk("R4 empty again", d, 32'h8000_0000);
    rx_push(8'h44, a);
    rd(A_RXD, d); chk("R4 no wrap after empty", d, 32'h44);
  endtask

  task automatic t_rx_full;
    logic [31:0] d; logic a;
    for (int i = 0; i < 8; i++) begin
      rx_push(8'hA0 + 8'(i), a); chk("R5 accept", {31'b0, a}, 1);
    end
    chk("R5 ready low", {31'b0, rx_ready}, 0);
    rx_push(8'hEE, a); chk("R5 ninth refused", {31'b0, a}, 0);
    for (int i = 0; i < 8; i++) begin
      rd(A_RXD, d); chk("R5 kept", d, 32'hA0 + i);
    end
    rd(A_RXD, d); chk("R5 ninth dropped", d, 32'h8000_0000);
  endtask

  task automatic t_rx_wm;
    logic [31:0] d; logic a;
    wr(A_RXC, 32'h0002_0000);
    rx_push(8'h01, a); rx_push(8'h02, a);
    rd(A_IPD, d); chk("R8 level2 mark2", d, 0);
    wr(A_IEN, 32'h2);
    chk("R10 irq off at mark", {31'b0, irq}, 0);
    rx_push(8'h03, a);
    rd(A_IPD, d); chk("R8 level3 mark2", d, 32'h2);
    chk("R10 irq on", {31'b0, irq}, 1);
    rd(A_RXD, d);
    chk("R10 irq falls", {31'b0, irq}, 0);
    rd(A_RXD, d); rd(A_RXD, d);
    wr(A_IEN, 0); wr(A_RXC, 0);
  endtask

  task automatic t_tx;
    logic [7:0] b; logic v;
    wr(A_TXD, 32'hFFFF_FF41);
    chk("R6 valid", {31'b0, tx_valid}, 1);
    chk("R6 low byte", {24'b0, tx_data}, 32'h41);
    wr(A_TXD, 32'h0000_0142); wr(A_TXD, 32'h0000_0043);
    tx_pop(b, v); chk("R6 pop1", {23'b0, v, b}, 32'h141);
    tx_pop(b, v); chk("R6 pop2", {23'b0, v, b}, 32'h142);
    tx_pop(b, v); chk("R6 pop3", {23'b0, v, b}, 32'h143);
    chk("R6 empty", {31'b0, tx_valid}, 0);
  endtask

  task automatic t_tx_full;
    logic [7:0] b; logic v;
    for (int i = 0; i < 9; i++) wr(A_TXD, 32'h50 + i);
    for (int i = 0; i < 8; i++) begin
      tx_pop(b, v); chk("R7 order", {23'b0, v, b}, 32'h150 + i);
    end
    chk("R7 ninth dropped", {31'b0, tx_valid}, 0);
  endtask

  task automatic t_tx_wm;
    logic [31:0] d; logic [7:0] b; logic v;
    wr(A_TXC, 32'h0003_0000);
    rd(A_IPD, d); chk("R9 level0 mark3", d, 32'h1);
    wr(A_IEN, 32'h1);
    chk("R10 tx irq on", {31'b0, irq}, 1);
    wr(A_TXD, 1); wr(A_TXD, 2);
    rd(A_IPD, d); chk("R9 level2 mark3", d, 32'h1);
    wr(A_TXD, 3);
    rd(A_IPD, d); chk("R9 level3 mark3", d, 0);
    chk("R10 tx irq off", {31'b0, irq}, 0);
    tx_pop(b, v);
    chk("R10 tx irq back", {31'b0, irq}, 1);
    tx_pop(b, v); tx_pop(b, v);
    wr(A_IEN, 0); wr(A_TXC, 0);
  endtask

  task automatic t_bad;
    logic [31:0] d; logic a;
    wr(A_DIV, 32'h0000_0100);
    wr(A_DIV, 32'hFFFF_FFFF, 4'h3);
    rd(A_DIV, d); chk("R11 partial write ignored", d, 32'h100);
    rd(A_DIV, d, 4'h1); chk("R11 partial read zero", d, 0);
    rd(8'h1C, d); chk("R11 unmapped read", d, 0);
    rd(8'h19, d); chk("R11 unaligned read", d, 0);
    wr(A_IPD, 32'h3);
    rd(A_IPD, d); chk("R11 pending not writable", d, 0);
    rx_push(8'h77, a);
    rd(A_RXD, d, 4'h7); chk("R11 partial rx read", d, 0);
    rd(8'h05, d); chk("R11 unaligned rx read", d, 0);
    rd(A_RXD, d); chk("R11 no pop", d, 32'h77);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_csr(); t_rx_order(); t_rx_full(); t_rx_wm();
    t_tx(); t_tx_full(); t_tx_wm(); t_bad();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule